// File: doc/BRIEF.md
# Horizontal Sync Lock Tracker

This block decides whether a horizontal-sync train is stable enough for a downstream sync filter to be switched on. Once per video line the sync front end raises a one-cycle strobe together with a verdict: the expected sync edge either arrived valid, or it was missing or invalid. The tracker counts these verdicts against two separate 8-bit thresholds. One threshold sets how many consecutive valid syncs are needed before filtering starts. The other sets how many bad syncs end it. Because the two thresholds are independent, the lock has hysteresis.

The output `filter_active` is the lock flag and drives the filter's enable directly. `lock_pulse` and `unlock_pulse` mark each change of the flag for one cycle. The thresholds are static configuration inputs, held in a configuration register outside the block. Values of 32 for the lock threshold and 50 for the unlock threshold give a typical setting. A threshold should only be changed while the block is held in reset.

The controller has two states. In `ST_SEEK` it accumulates a run of valid syncs, and reaching the lock threshold causes the transition SEEK→TRACK. In `ST_TRACK` it accumulates bad syncs, and reaching the unlock threshold causes the transition TRACK→SEEK. A run of valid syncs equal to the lock threshold while in `ST_TRACK` is a self-transition that clears the bad-sync tally.

Top module: `hsync_lock_tracker`

## Requirements
- R1: After reset `filter_active`, `lock_pulse` and `unlock_pulse` are all 0.
- R2: In SEEK, the strobe that completes a run of `lock_thr` consecutive valid syncs (`line_ok`=1) sets `filter_active` to 1 from the clock edge that samples that strobe. Fewer valid syncs leave it at 0.
- R3: In SEEK, a strobe with `line_ok`=0 restarts the valid-sync run from zero.
- R4: In TRACK, bad syncs are counted cumulatively, and valid syncs in between do not reset that count. The strobe that brings the count to `unlock_thr` clears `filter_active` from the edge that samples it.
- R5: In TRACK, a run of `lock_thr` consecutive valid syncs clears the bad-sync count, and `filter_active` stays at 1.
- R6: A threshold value of 0 acts as 1, so a single qualifying strobe causes the transition.
- R7: `lock_pulse` is high for exactly the one cycle in which `filter_active` first reads 1. `unlock_pulse` is high for exactly the one cycle in which it first reads 0 again. The two pulses are never high together.
- R8: While `line_stb` is 0, `line_ok` has no effect: no output and no count changes.
- R9: A threshold of 255 works. The counts saturate at 255 and never wrap, so 254 valid syncs leave the block in SEEK and the 255th locks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle strobe per line carrying a sync verdict |
| line_ok | input | 1 | Verdict: 1 = sync valid, 0 = missing or invalid |
| lock_thr | input | 8 | Consecutive valid syncs needed for lock (0 acts as 1) |
| unlock_thr | input | 8 | Bad syncs that drop lock (0 acts as 1) |
| filter_active | output | 1 | Lock flag and sync-filter enable |
| lock_pulse | output | 1 | One-cycle pulse when lock is gained |
| unlock_pulse | output | 1 | One-cycle pulse when lock is lost |

## Verification
The assertions check on every cycle that the flag changes only on a strobe, that it rises only on a valid verdict and falls only on a bad one, and that each pulse coincides with the matching edge of the flag, lasts one cycle and never overlaps the other. Only the bench scenarios can show the counting itself. That includes the exact number of strobes needed in each direction, the restart of a valid run after a bad sync, the cumulative bad tally and its clearing by a valid run, and the treatment of zero and 255 thresholds. The bench covers these with directed cases and with a sweep over small thresholds that is checked against an arithmetic model.

// File: rtl/hlt_pkg.sv
package hlt_pkg;
    localparam int CNT_W = 8;

    typedef enum logic [0:0] {
        ST_SEEK  = 1'b0,
        ST_TRACK = 1'b1
    } hlt_state_t;
endpackage

// File: rtl/hlt_sat_ctr.sv
module hlt_sat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hlt_reach.sv
module hlt_reach #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] thr,
    output logic         hit
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] eff;
    logic [W:0]   nxt;

    always_comb begin
        eff = (thr == '0) ? ONE : thr;
        nxt = {1'b0, cnt} + (W+1)'(1);
        hit = (nxt >= {1'b0, eff});
    end
endmodule

// File: rtl/hsync_lock_tracker.sv
module hsync_lock_tracker
    import hlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb,
    input  logic             line_ok,
    input  logic [CNT_W-1:0] lock_thr,
    input  logic [CNT_W-1:0] unlock_thr,
    output logic             filter_active,
    output logic             lock_pulse,
    output logic             unlock_pulse
);
    hlt_state_t state, state_nxt;

    logic good_ev, bad_ev;
    logic good_hit, bad_hit;
    logic good_clr, bad_clr;
    logic [CNT_W-1:0] good_cnt, bad_cnt;

    assign good_ev = line_stb && line_ok;
    assign bad_ev  = line_stb && !line_ok;

    hlt_sat_ctr #(.W(CNT_W)) u_good_ctr (
        .clk(clk), .rst_n(rst_n), .clr(good_clr), .inc(good_ev), .cnt(good_cnt)
    );

    hlt_sat_ctr #(.W(CNT_W)) u_bad_ctr (
        .clk(clk), .rst_n(rst_n), .clr(bad_clr), .inc(bad_ev), .cnt(bad_cnt)
    );

    hlt_reach #(.W(CNT_W)) u_good_reach (
        .cnt(good_cnt), .thr(lock_thr), .hit(good_hit)
    );

    hlt_reach #(.W(CNT_W)) u_bad_reach (
        .cnt(bad_cnt), .thr(unlock_thr), .hit(bad_hit)
    );

    // next state and counter control
    always_comb begin
        state_nxt = state;
        good_clr  = 1'b0;
        bad_clr   = 1'b0;
        unique case (state)
            ST_SEEK: begin
                bad_clr = 1'b1;
                if (bad_ev) begin
                    good_clr = 1'b1;
                end else if (good_ev && good_hit) begin
                    good_clr  = 1'b1;
                    state_nxt = ST_TRACK;
                end
            end
            ST_TRACK: begin
                if (bad_ev) begin
                    good_clr = 1'b1;
                    if (bad_hit) begin
                        bad_clr   = 1'b1;
                        state_nxt = ST_SEEK;
                    end
                end else if (good_ev && good_hit) begin
                    good_clr = 1'b1;
                    bad_clr  = 1'b1;
                end
            end
            default: state_nxt = ST_SEEK;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SEEK;
        end else begin
            state <= state_nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filter_active <= 1'b0;
            lock_pulse    <= 1'b0;
            unlock_pulse  <= 1'b0;
        end else begin
            filter_active <= (state_nxt == ST_TRACK);
            lock_pulse    <= (state == ST_SEEK)  && (state_nxt == ST_TRACK);
            unlock_pulse  <= (state == ST_TRACK) && (state_nxt == ST_SEEK);
        end
    end
endmodule

// File: rtl/hlt_checker.sv
module hlt_checker (
    input logic clk,
    input logic rst_n,
    input logic line_stb,
    input logic line_ok,
    input logic filter_active,
    input logic lock_pulse,
    input logic unlock_pulse
);
    // R8: flag moves only on a strobe
    a_r8_flag_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(line_stb) |-> $stable(filter_active));

    // R2: lock is gained only on a valid verdict
    a_r2_rise_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filter_active) |-> $past(line_ok));

    // R4: lock is lost only on a bad verdict
    a_r4_fall_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filter_active) |-> !$past(line_ok));

    a_r7_lock_pulse_edge: assert property (@(posedge clk) disable iff (!rst_n)
        lock_pulse == $rose(filter_active));

    a_r7_unlock_pulse_edge: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_pulse == $fell(filter_active));

    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_pulse || unlock_pulse) |=> !(lock_pulse || unlock_pulse));

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_pulse && unlock_pulse));
endmodule

bind hsync_lock_tracker hlt_checker u_hlt_checker (
    .clk(clk),
    .rst_n(rst_n),
    .line_stb(line_stb),
    .line_ok(line_ok),
    .filter_active(filter_active),
    .lock_pulse(lock_pulse),
    .unlock_pulse(unlock_pulse)
);

// File: tb/hsync_lock_tracker_bench.sv
module hsync_lock_tracker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0;
    logic       line_ok = 1'b0;
    logic [7:0] lock_thr = 8'd4;
    logic [7:0] unlock_thr = 8'd3;
    logic       filter_active, lock_pulse, unlock_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int m_lock, m_good, m_bad, m_pl, m_pu;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    hsync_lock_tracker u_hsync_lock_tracker (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .line_ok(line_ok),
        .lock_thr(lock_thr), .unlock_thr(unlock_thr),
        .filter_active(filter_active), .lock_pulse(lock_pulse),
        .unlock_pulse(unlock_pulse)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " flag"}, int'(filter_active), m_lock);
        check({tag, " lock_pulse"}, int'(lock_pulse), m_pl);
        check({tag, " unlock_pulse"}, int'(unlock_pulse), m_pu);
    endtask

    task automatic do_reset(input int lt, input int ut);
        @(negedge clk);
        rst_n = 1'b0; line_stb = 1'b0; line_ok = 1'b0;
        lock_thr = 8'(lt); unlock_thr = 8'(ut);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_lock = 0; m_good = 0; m_bad = 0; m_pl = 0; m_pu = 0;
    endtask

    // model of one strobe, computed from the requirements
    task automatic model(input bit ok);
        int el, eu;
        el = (lock_thr == 0) ? 1 : int'(lock_thr);
        eu = (unlock_thr == 0) ? 1 : int'(unlock_thr);
        m_pl = 0; m_pu = 0;
        if (ok) begin
            m_good = (m_good < 255) ? m_good + 1 : 255;
            if (m_good >= el) begin
                m_good = 0; m_bad = 0;
                if (m_lock == 0) begin m_lock = 1; m_pl = 1; end
            end
        end else begin
            m_good = 0;
            if (m_lock == 1) begin
                m_bad = (m_bad < 255) ? m_bad + 1 : 255;
                if (m_bad >= eu) begin m_lock = 0; m_pu = 1; m_bad = 0; end
            end
        end
    endtask

    task automatic strobe(input bit ok, input string tag);
        @(negedge clk);
        line_stb = 1'b1; line_ok = ok;
        model(ok);
        @(negedge clk);
        line_stb = 1'b0;
        check_all(tag);
        m_pl = 0; m_pu = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(4, 3);
        check_all("R1 reset");

        // R2 lock after exactly four valid syncs, R7 pulse lasts one cycle
        for (int i = 0; i < 4; i++) strobe(1'b1, "R2 lock run");
        check(filter_active ? "R2 locked" : "R2 locked", int'(filter_active), 1);
        @(negedge clk);
        check("R7 pulse dropped", int'(lock_pulse), 0);

        // R3 bad sync restarts the run
        do_reset(4, 3);
        for (int i = 0; i < 3; i++) strobe(1'b1, "R3 pre");
        strobe(1'b0, "R3 break");
        for (int i = 0; i < 3; i++) strobe(1'b1, "R3 restart");
        check("R3 still unlocked", int'(filter_active), 0);
        strobe(1'b1, "R3 lock");

        // R4 cumulative bad count with valid syncs in between
        for (int i = 0; i < 2; i++) begin
            strobe(1'b0, "R4 bad");
            strobe(1'b1, "R4 good");
        end
        check("R4 held", int'(filter_active), 1);
        strobe(1'b0, "R4 unlock");
        check("R4 unlocked", int'(filter_active), 0);

        // R5 valid run clears bad tally
        do_reset(4, 3);
        for (int i = 0; i < 4; i++) strobe(1'b1, "R5 lock");
        strobe(1'b0, "R5 bad");
        strobe(1'b0, "R5 bad");
        for (int i = 0; i < 4; i++) strobe(1'b1, "R5 clear");
        strobe(1'b0, "R5 bad");
        strobe(1'b0, "R5 bad");
        check("R5 held", int'(filter_active), 1);
        strobe(1'b0, "R5 third");

        // R6 zero thresholds act as one
        do_reset(0, 0);
        strobe(1'b1, "R6 lock");
        check("R6 lock one", int'(filter_active), 1);
        strobe(1'b0, "R6 unlock");
        check("R6 unlock one", int'(filter_active), 0);

        // R8 line_ok ignored without strobe
        do_reset(2, 2);
        strobe(1'b1, "R8 one");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            line_ok = ~line_ok;
        end
        strobe(1'b0, "R8 bad");
        strobe(1'b1, "R8 after");
        check("R8 no lock", int'(filter_active), 0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            line_ok = i[0];
            check("R8 idle", int'(filter_active), 0);
        end

        // R9 largest threshold
        do_reset(255, 255);
        for (int i = 0; i < 254; i++) strobe(1'b1, "R9 run");
        check("R9 254", int'(filter_active), 0);
        strobe(1'b1, "R9 255th");
        check("R9 locked", int'(filter_active), 1);

        // sweep of small thresholds against the model, R2/R3/R4/R5/R7
        for (int lt = 0; lt < 6; lt++) begin
            for (int ut = 0; ut < 5; ut++) begin
                do_reset(lt, ut);
                for (int k = 0; k < 200; k++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    strobe((k % 50 < 25) ? (lfsr[3:0] != 4'd0) : (lfsr[1:0] != 2'd0),
                           "R2/R4 sweep");
                end
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule